// File: doc/BRIEF.md
# Serial Wire Debug Host Transfer Engine

This block is the host end of a two-wire serial debug link. For each command it runs one complete register transfer to a debug port or access port, a line-reset sequence, or a run of idle cycles. It drives the link clock and owns the bidirectional data line through an output-enable, giving the line up to the target during turnaround. It returns the target's 3-bit acknowledge, the 32-bit read word and a parity-error flag.

A higher-level controller chooses which registers to touch and decides whether to retry after WAIT. The engine frames the 8-bit request with its parity and places the turnaround cycles, which differ between reads and writes. It shifts every field least-significant bit first. When the acknowledge is not OK, it drops the data phase and takes the line back. The link clock comes from a programmable divider. The host changes the data line while the clock is low, and target data is sampled at the rising edge.

Top module: `swd_xfer_engine`

## Requirements
- R1: A transfer begins with 8 host-driven request slots carrying, in order, 1, port select (`ap_ndp_i`, 1 = access port), `rnw_i` (1 = read), `addr_i[0]`, `addr_i[1]`, parity, 0, 1.
- R2: The request parity bit is 1 exactly when an odd number of port select, `rnw_i`, `addr_i[0]` and `addr_i[1]` are 1.
- R3: The acknowledge is taken from the three target slots after the first turnaround, first slot into bit 0, and is reported on `ack_o` (OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100).
- R4: A write with OK acknowledge uses 46 slots: request, turnaround, 3 acknowledge slots, turnaround, then 32 host-driven data bits LSB first and their even parity bit, with no turnaround after them.
- R5: A read with OK acknowledge uses 46 slots: request, turnaround, then acknowledge, 32 data bits LSB first and a parity bit all driven by the target, then one turnaround; the word appears on `rdata_o`.
- R6: `perr_o` is 1 after a read whose received parity bit differs from the even parity of the received word, and 0 otherwise, including after every write.
- R7: When the acknowledge is not OK, the data phase is skipped and the transfer ends after 13 slots (request, turnaround, acknowledge, turnaround), with the line driven by the host again.
- R8: `ack_err_o` is 1 when the acknowledge is none of OK, WAIT or FAULT (for example 3'b111 from an undriven pulled-up line).
- R9: Command `op_i` = 1 drives the line high for LRST_HI (default 50) slots and then low for LRST_LO (default 2) slots.
- R10: Command `op_i` = 2 (3 acts the same) drives `idle_len_i` low slots, a value of 0 giving one slot.
- R11: The link clock period is 2*(`div_i`+1) clock cycles; the clock is low when the engine is idle, and the host changes its data line only while the link clock is low.
- R12: `start_i` is accepted only when `busy_o` is 0; a start during a sequence has no effect, and `done_o` pulses for one cycle when a sequence ends.
- R13: After reset the link clock is 0, the host drives the data line low, and `busy_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Half-period of the link clock minus one, in clock cycles |
| start_i | input | 1 | Start a sequence (accepted when idle) |
| op_i | input | 2 | 0 transfer, 1 line reset, 2 or 3 idle cycles |
| ap_ndp_i | input | 1 | 1 selects an access port, 0 the debug port |
| rnw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 2 | Register address bits 3:2 |
| wdata_i | input | DW | Write word |
| idle_len_i | input | CNT_W | Number of idle slots |
| swclk_o | output | 1 | Link clock |
| swdio_o | output | 1 | Host data out |
| swdio_oe_o | output | 1 | Host drives the data line when 1 |
| swdio_i | input | 1 | Data line as seen at the pin |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ack_o | output | 3 | Acknowledge of the last transfer |
| rdata_o | output | DW | Word of the last read |
| perr_o | output | 1 | Read parity mismatch on the last transfer |
| ack_err_o | output | 1 | Last acknowledge was not a legal code |

## Verification
All 16 combinations of port select, direction and register address are run with OK acknowledges. Their varied data words separate request framing and parity errors from mistakes in data bit order. Reads alternate good and flipped parity bits, which separates a working parity check from a flag stuck at one value. Every acknowledge code is returned, and the undriven case is included. These runs tell a correct early exit and the LSB-first order of the acknowledge apart from a swapped or shifted one. Line reset, idle lengths including zero, two divider settings, and a start pulse issued mid-transfer cover the sequencing boundaries.

// File: rtl/swd_xfer_pkg.sv
package swd_xfer_pkg;
  localparam logic [1:0] OP_XFER = 2'd0;
  localparam logic [1:0] OP_LRST = 2'd1;
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  typedef enum logic [3:0] {
    S_IDLE, S_ARM, S_REQ, S_TRN_A, S_ACK, S_TRN_W,
    S_WDAT, S_RDAT, S_TRN_E, S_LHI, S_LLO, S_IDL
  } swd_st_e;
endpackage

// File: rtl/swd_clk_div.sv
module swd_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             ph_q;
  logic             wrap;

  assign wrap   = en_i && (cnt_q >= div_i);
  assign rise_o = wrap && !ph_q;
  assign fall_o = wrap && ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= !ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R11
  edge_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/swd_req_frame.sv
module swd_req_frame (
  input  logic       ap_ndp_i,
  input  logic       rnw_i,
  input  logic [1:0] addr_i,
  output logic [7:0] req_o
);
  logic par;
  assign par   = ap_ndp_i ^ rnw_i ^ addr_i[0] ^ addr_i[1];
  // index = wire slot
  assign req_o = {1'b1, 1'b0, par, addr_i[1], addr_i[0], rnw_i, ap_ndp_i, 1'b1};
endmodule

// File: rtl/swd_xfer_engine.sv
module swd_xfer_engine
  import swd_xfer_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int CNT_W   = 8,
  parameter int DW      = 32,
  parameter int LRST_HI = 50,
  parameter int LRST_LO = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             ap_ndp_i,
  input  logic             rnw_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CNT_W-1:0] idle_len_i,
  output logic             swclk_o,
  output logic             swdio_o,
  output logic             swdio_oe_o,
  input  logic             swdio_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       ack_o,
  output logic [DW-1:0]    rdata_o,
  output logic             perr_o,
  output logic             ack_err_o
);
  localparam int IDX_W = $clog2(DW);
  localparam logic [CNT_W-1:0] CNT_DAT = CNT_W'(DW);
  localparam logic [CNT_W-1:0] CNT_HI  = CNT_W'(LRST_HI - 1);
  localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(LRST_LO - 1);

  swd_st_e          st_q;
  logic [CNT_W-1:0] cnt_q, idle_q;
  logic [1:0]       op_q, addr_q;
  logic             ap_q, rnw_q, swclk_q, rpar_q, done_q;
  logic [DW-1:0]    wdata_q, rsh_q;
  logic [2:0]       ack_sh_q;
  logic [7:0]       req;
  logic             rise, fall, fin, ack_ok;

  swd_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(st_q != S_IDLE),
    .div_i (div_i), .rise_o(rise),   .fall_o(fall)
  );

  swd_req_frame u_req (
    .ap_ndp_i(ap_q), .rnw_i(rnw_q), .addr_i(addr_q), .req_o(req)
  );

  assign ack_ok  = (ack_sh_q == ACK_OK);
  assign swclk_o = swclk_q;
  assign busy_o  = (st_q != S_IDLE);
  assign done_o  = done_q;

  always_comb begin
    fin = 1'b0;
    if (fall) begin
      unique case (st_q)
        S_WDAT:  fin = (cnt_q == CNT_DAT);
        S_TRN_E: fin = 1'b1;
        S_LLO:   fin = (cnt_q == CNT_LO);
        S_IDL:   fin = (cnt_q == idle_q - CNT_W'(1));
        default: fin = 1'b0;
      endcase
    end
  end

  // line ownership per slot
  always_comb begin
    swdio_oe_o = 1'b1;
    swdio_o    = 1'b0;
    unique case (st_q)
      S_REQ:  swdio_o = req[cnt_q[2:0]];
      S_WDAT: swdio_o = (cnt_q == CNT_DAT) ? ^wdata_q : wdata_q[cnt_q[IDX_W-1:0]];
      S_LHI:  swdio_o = 1'b1;
      S_TRN_A, S_ACK, S_TRN_W, S_RDAT, S_TRN_E: swdio_oe_o = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      idle_q    <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      ap_q      <= 1'b0;
      rnw_q     <= 1'b0;
      wdata_q   <= '0;
      rsh_q     <= '0;
      rpar_q    <= 1'b0;
      ack_sh_q  <= '0;
      swclk_q   <= 1'b0;
      done_q    <= 1'b0;
      ack_o     <= '0;
      rdata_o   <= '0;
      perr_o    <= 1'b0;
      ack_err_o <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (start_i) begin
          st_q     <= S_ARM;
          cnt_q    <= '0;
          op_q     <= op_i;
          ap_q     <= ap_ndp_i;
          rnw_q    <= rnw_i;
          addr_q   <= addr_i;
          wdata_q  <= wdata_i;
          idle_q   <= (idle_len_i == '0) ? CNT_W'(1) : idle_len_i;
          ack_sh_q <= '0;
          rsh_q    <= '0;
          rpar_q   <= 1'b0;
        end
      end else begin
        if (rise) begin
          swclk_q <= 1'b1;
          if (st_q == S_ACK) ack_sh_q[cnt_q[1:0]] <= swdio_i;
          if (st_q == S_RDAT) begin
            if (cnt_q == CNT_DAT) rpar_q <= swdio_i;
            else rsh_q[cnt_q[IDX_W-1:0]] <= swdio_i;
          end
        end
        if (fall) begin
          swclk_q <= 1'b0;
          cnt_q   <= cnt_q + CNT_W'(1);
          unique case (st_q)
            S_ARM: begin
              cnt_q <= '0;
              if (op_q == OP_XFER)      st_q <= S_REQ;
              else if (op_q == OP_LRST) st_q <= S_LHI;
              else                      st_q <= S_IDL;
            end
            S_REQ:   if (cnt_q == CNT_W'(7)) begin st_q <= S_TRN_A; cnt_q <= '0; end
            S_TRN_A: begin st_q <= S_ACK; cnt_q <= '0; end
            S_ACK: if (cnt_q == CNT_W'(2)) begin
              cnt_q <= '0;
              if (!ack_ok)   st_q <= S_TRN_E;
              else if (rnw_q) st_q <= S_RDAT;
              else           st_q <= S_TRN_W;
            end
            S_TRN_W: begin st_q <= S_WDAT; cnt_q <= '0; end
            S_RDAT:  if (cnt_q == CNT_DAT) begin st_q <= S_TRN_E; cnt_q <= '0; end
            S_LHI:   if (cnt_q == CNT_HI) begin st_q <= S_LLO; cnt_q <= '0; end
            default: ;
          endcase
          if (fin) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b1;
            if (op_q == OP_XFER) begin
              ack_o     <= ack_sh_q;
              ack_err_o <= !(ack_sh_q == ACK_OK || ack_sh_q == ACK_WAIT ||
                             ack_sh_q == ACK_FAULT);
              perr_o    <= rnw_q && ack_ok && ((^rsh_q) != rpar_q);
              if (rnw_q && ack_ok) rdata_o <= rsh_q;
            end
          end
        end
      end
    end
  end

  // R11
  data_lowclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((swdio_o != $past(swdio_o)) || (swdio_oe_o != $past(swdio_oe_o))) |-> !swclk_o);
  // R11
  clk_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swclk_o) |-> busy_o);
  // R12
  done_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!swclk_o && swdio_oe_o && !busy_o));
  // R6
  perr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && perr_o) |-> (ack_o == ACK_OK && rnw_q));
  // R8
  ackerr_noperr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ack_err_o) |-> !perr_o);
endmodule

// File: tb/swd_xfer_engine_tb_top.sv
module swd_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div = 8'd1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        ap = 1'b0, rnw = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [7:0]  idle_len = 8'd0;
  logic        swclk, swdio_o, swdio_oe, busy, done, perr, ack_err;
  logic [2:0]  ack;
  logic [31:0] rdata;
  logic        tgt_en = 1'b0, tgt_v = 1'b0;
  logic        dio;

  int checks = 0, errs = 0;
  int slot_abs = 0, slot_base = 0, cont_abs = 0, cont_base = 0;
  int cyc = 0, per_last = 0, per_val = 0;
  logic hoe [64];
  logic hv  [64];
  logic pe  [64];
  logic pv  [64];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign dio = swdio_oe ? swdio_o : (tgt_en ? tgt_v : 1'b1);

  swd_xfer_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .start_i(start), .op_i(op),
    .ap_ndp_i(ap), .rnw_i(rnw), .addr_i(addr), .wdata_i(wdata),
    .idle_len_i(idle_len), .swclk_o(swclk), .swdio_o(swdio_o),
    .swdio_oe_o(swdio_oe), .swdio_i(dio), .busy_o(busy), .done_o(done),
    .ack_o(ack), .rdata_o(rdata), .perr_o(perr), .ack_err_o(ack_err)
  );

  // target model: records host slots, drives its own after each rising edge
  always @(posedge swclk) begin
    automatic int idx = slot_abs - slot_base;
    if (idx < 64) begin
      hoe[idx] = swdio_oe;
      hv[idx]  = swdio_o;
    end
    if (swdio_oe && tgt_en) cont_abs = cont_abs + 1;
    per_val  = cyc - per_last;
    per_last = cyc;
    slot_abs = slot_abs + 1;
    if (idx + 1 < 64) begin
      tgt_en <= pe[idx+1];
      tgt_v  <= pv[idx+1];
    end else tgt_en <= 1'b0;
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic prep();
    for (int i = 0; i < 64; i++) begin pe[i] = 1'b0; pv[i] = 1'b0; end
  endtask

  task automatic plan_ack(input bit drv, input logic [2:0] a);
    for (int i = 0; i < 3; i++) begin pe[9+i] = drv; pv[9+i] = a[i]; end
  endtask

  task automatic plan_rd(input logic [31:0] d, input bit flip);
    for (int i = 0; i < 32; i++) begin pe[12+i] = 1'b1; pv[12+i] = d[i]; end
    pe[44] = 1'b1; pv[44] = (^d) ^ flip;
  endtask

  task automatic go(input logic [1:0] o, input logic a, input logic r,
                    input logic [1:0] ad, input logic [31:0] wd, input logic [7:0] il);
    @(negedge clk);
    slot_base = slot_abs; cont_base = cont_abs;
    op = o; ap = a; rnw = r; addr = ad; wdata = wd; idle_len = il; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 20000; t++) begin
      if (done) break;
      @(negedge clk);
    end
    if (!done) chk(1'b0, "R12 done timeout", 0, 1);
  endtask

  function automatic logic [7:0] req_exp(input logic a, input logic r, input logic [1:0] ad);
    return {1'b1, 1'b0, a ^ r ^ ad[0] ^ ad[1], ad[1], ad[0], r, a, 1'b1};
  endfunction

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [7:0]  rq;
    logic [31:0] wb;
    int bad;
    prep();
    repeat (4) @(negedge clk);
    // R13
    chk(swclk == 1'b0 && swdio_oe == 1'b1 && swdio_o == 1'b0 && busy == 1'b0 && done == 1'b0,
        "R13 reset state", {swclk, swdio_oe, swdio_o, busy, done}, 5'b01000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // sweep all request combinations with OK acknowledge
    for (int k = 0; k < 16; k++) begin
      automatic logic       a_k = k[3];
      automatic logic       r_k = k[2];
      automatic logic [1:0] ad_k = k[1:0];
      automatic logic [31:0] wd = 32'h9E37_79B9 * (k + 1);
      automatic logic [31:0] rd = 32'h85EB_CA6B ^ (32'h1 << k) ^ (k * 32'h0101_0003);
      automatic bit flip = (k % 3 == 0);
      prep();
      plan_ack(1'b1, 3'b001);
      if (r_k) plan_rd(rd, flip);
      go(2'd0, a_k, r_k, ad_k, wd, 8'd0);
      for (int i = 0; i < 8; i++) rq[i] = hv[i];
      // R1 R2
      chk(rq == req_exp(a_k, r_k, ad_k), "R1 R2 request bits", rq, req_exp(a_k, r_k, ad_k));
      chk(slot_abs - slot_base == 46, r_k ? "R5 slot count" : "R4 slot count",
          slot_abs - slot_base, 46);
      bad = 0;
      for (int s = 0; s < 46; s++) begin
        automatic logic eo = (s < 8) || (!r_k && s >= 13);
        if (hoe[s] !== eo) bad++;
      end
      chk(bad == 0, r_k ? "R5 line ownership" : "R4 line ownership", bad, 0);
      chk(ack == 3'b001 && !ack_err, "R3 ack OK", {ack_err, ack}, 4'b0001);
      chk(cont_abs == cont_base, "R11 no contention", cont_abs - cont_base, 0);
      if (r_k) begin
        chk(rdata == rd, "R5 read word", rdata, rd);
        chk(perr == flip, "R6 read parity", perr, flip);
      end else begin
        for (int i = 0; i < 32; i++) wb[i] = hv[13+i];
        chk(wb == wd, "R4 write word", wb, wd);
        chk(hv[45] == ^wd, "R4 write parity", hv[45], ^wd);
        chk(perr == 1'b0, "R6 write no perr", perr, 0);
      end
    end

    // non-OK acknowledges, each code, plus an undriven line
    for (int a = 0; a < 9; a++) begin
      automatic logic [2:0] av = (a == 8) ? 3'b111 : a[2:0];
      automatic bit drv = (a != 8);
      if (a == 1) continue;
      prep();
      plan_ack(drv, av);
      go(2'd0, 1'b1, a[0], 2'd3, 32'hFFFF_0000, 8'd0);
      chk(slot_abs - slot_base == 13, "R7 early end slots", slot_abs - slot_base, 13);
      chk(ack == av, "R3 ack bit order", ack, av);
      chk(ack_err == !(av == 3'b010 || av == 3'b100), "R8 ack error flag", ack_err,
          !(av == 3'b010 || av == 3'b100));
      chk(perr == 1'b0 && swdio_oe == 1'b1, "R7 line back, no perr", {perr, swdio_oe}, 2'b01);
    end

    // line reset
    prep();
    go(2'd1, 1'b0, 1'b0, 2'd0, '0, 8'd0);
    bad = 0;
    for (int s = 0; s < 52; s++) if (hoe[s] !== 1'b1 || hv[s] !== (s < 50)) bad++;
    chk(slot_abs - slot_base == 52 && bad == 0, "R9 line reset", {slot_abs - slot_base, bad}, 52 << 32);

    // idle slots
    prep();
    go(2'd2, 1'b0, 1'b0, 2'd0, '0, 8'd5);
    bad = 0;
    for (int s = 0; s < 5; s++) if (hoe[s] !== 1'b1 || hv[s] !== 1'b0) bad++;
    chk(slot_abs - slot_base == 5 && bad == 0, "R10 idle five", slot_abs - slot_base, 5);
    prep();
    go(2'd3, 1'b0, 1'b0, 2'd0, '0, 8'd0);
    chk(slot_abs - slot_base == 1 && hv[0] == 1'b0, "R10 idle zero", slot_abs - slot_base, 1);

    // clock period at two divider settings
    for (int d = 0; d < 2; d++) begin
      div = (d == 0) ? 8'd0 : 8'd3;
      prep();
      go(2'd2, 1'b0, 1'b0, 2'd0, '0, 8'd4);
      chk(per_val == 2 * (div + 1), "R11 clock period", per_val, 2 * (div + 1));
      chk(swclk == 1'b0, "R11 clock low when idle", swclk, 0);
    end
    div = 8'd1;

    // start while busy is ignored
    prep();
    plan_ack(1'b1, 3'b001);
    plan_rd(32'h1234_5678, 1'b0);
    @(negedge clk);
    slot_base = slot_abs;
    op = 2'd0; ap = 1'b0; rnw = 1'b1; addr = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    op = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 20000; t++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(rdata == 32'h1234_5678 && slot_abs - slot_base == 46, "R12 mid start ignored",
        rdata, 32'h1234_5678);
    repeat (200) @(negedge clk);
    chk(!busy && slot_abs - slot_base == 46, "R12 no follow-on sequence",
        {busy, slot_abs - slot_base}, 46);

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule